// File: doc/BRIEF.md
# Serial flash command front-end

This block is the slave-side command interpreter of a serial NOR flash device. It watches the serial bus pins (an active-low select, a serial clock and a serial data input) and drives the serial data output. It oversamples all three inputs with the chip's own clock. From the samples it builds the command byte and, where the command takes one, a 24-bit address sent high byte first. It keeps the write-enable latch and answers status and identification reads itself. Program, erase, status-write and power-down requests go to a backend over a one-cycle request pulse.

The backend holds the array and its timing. While an operation runs it raises `bk_busy`. During that time the front-end drops every command except the first status read. When busy falls, the write-enable latch clears. A write-type command is committed only when select is released after a whole number of bytes and, apart from power-down, only when the latch is set. A read may be cut off after any bit.

Top module: `sflash_cmd_fe`

## Requirements
- R1: The command byte is sampled MSB first on rising serial-clock edges after select falls and is decoded at its 8th bit. An unknown command byte (for example FFh) issues no request and never enables the output.
- R2: Command 06h sets the write-enable latch and 04h clears it. The first status byte is {bk_stat_hi[5:0], latch, busy}: bit 1 is the latch and bit 0 is `bk_busy`.
- R3: Command 05h streams the first status byte and 35h streams `bk_stat2`. Both go out MSB first and repeat for as long as select stays low. Output bits change after falling clock edges, and the first response bit is valid before the 9th rising edge.
- R4: Command 9Fh returns EFh, 40h, 15h and then 00h. Command ABh returns 14h repeatedly after three dummy bytes. Command 90h returns EFh after three address bytes and then 14h.
- R5: Commands 20h, 52h, D8h and 02h take three address bytes, high first. On release the front-end issues a request with `req_addr` and a `req_kind` of 2, 3, 4 or 1 respectively. Page program (02h) needs at least one data byte. Each completed data byte is strobed on `pgm_vld`/`pgm_byte`.
- R6: A write, program, erase or latch command whose total bit count at release is not a multiple of 8 issues no request and leaves the latch unchanged.
- R7: With the latch clear, status write, program and erase commands issue no request.
- R8: While `bk_busy` is high, every command except 05h is ignored: no request, no latch change and no output enable. During busy, 05h reports bit 0 as 1.
- R9: The latch clears when `bk_busy` falls.
- R10: `so_oe` is low and `so` is 0 whenever select is high or the command is not a read.
- R11: A read ended after any bit count leaves no effect on later commands.
- R12: Command 01h with one or two data bytes issues `req_kind` 0. The first data byte goes on `req_sr[7:0]` and the second on `req_sr[15:8]`. `req_sr_two` tells whether the second byte was sent. A 01h with no data byte issues no request.
- R13: Commands C7h and 60h issue `req_kind` 5 when the latch is set. Command B9h issues `req_kind` 6 regardless of the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial bus select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| bk_busy | input | 1 | Backend operation in progress |
| bk_stat_hi | input | 6 | Upper bits of the first status byte |
| bk_stat2 | input | 8 | Second status byte |
| req_vld | output | 1 | One-cycle request pulse |
| req_kind | output | 3 | Request kind: 0 status write, 1 program, 2/3/4 erase 4K/32K/64K, 5 erase all, 6 power-down |
| req_addr | output | 24 | Address for program or erase |
| req_sr | output | 16 | Status write data |
| req_sr_two | output | 1 | Second status byte present |
| pgm_vld | output | 1 | Program data byte strobe |
| pgm_byte | output | 8 | Program data byte |

## Verification
A wrong bit or byte counter can show up in two ways. One is a shifted or repeated status or ID byte on `so` within the first response byte. The other is a request that appears or disappears at the release of select, a few cycles after the edge. A latch in the wrong state shows up on the next 05h read as bit 1 of the returned byte. It also shows up at the next release as a program or erase that fires or does not. A stuck busy gate shows up as an ID read returning a value while the backend is busy, or as an erase accepted during busy.

// File: rtl/sflash_fe_pkg.sv
package sflash_fe_pkg;

  localparam logic [7:0] CMD_WEN    = 8'h06;
  localparam logic [7:0] CMD_WDIS   = 8'h04;
  localparam logic [7:0] CMD_STAT1  = 8'h05;
  localparam logic [7:0] CMD_STAT2  = 8'h35;
  localparam logic [7:0] CMD_STWR   = 8'h01;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_ERA4K  = 8'h20;
  localparam logic [7:0] CMD_ERA32K = 8'h52;
  localparam logic [7:0] CMD_ERA64K = 8'hD8;
  localparam logic [7:0] CMD_ALL_A  = 8'hC7;
  localparam logic [7:0] CMD_ALL_B  = 8'h60;
  localparam logic [7:0] CMD_SLEEP  = 8'hB9;
  localparam logic [7:0] CMD_JID    = 8'h9F;
  localparam logic [7:0] CMD_LEGID  = 8'hAB;
  localparam logic [7:0] CMD_MFID   = 8'h90;

  typedef enum logic [3:0] {
    MD_NONE, MD_STAT1, MD_STAT2, MD_JID, MD_LEGID, MD_MFID,
    MD_WEN, MD_WDIS, MD_STWR, MD_PROG, MD_ERA4K, MD_ERA32K,
    MD_ERA64K, MD_ERAALL, MD_SLEEP
  } mode_t;

  typedef enum logic [2:0] {
    RK_STWR   = 3'd0,
    RK_PROG   = 3'd1,
    RK_ERA4K  = 3'd2,
    RK_ERA32K = 3'd3,
    RK_ERA64K = 3'd4,
    RK_ERAALL = 3'd5,
    RK_SLEEP  = 3'd6
  } req_kind_t;

  function automatic mode_t cmd_decode(input logic [7:0] cmd, input logic busy);
    mode_t m;
    case (cmd)
      CMD_WEN:             m = MD_WEN;
      CMD_WDIS:            m = MD_WDIS;
      CMD_STAT1:           m = MD_STAT1;
      CMD_STAT2:           m = MD_STAT2;
      CMD_STWR:            m = MD_STWR;
      CMD_PROG:            m = MD_PROG;
      CMD_ERA4K:           m = MD_ERA4K;
      CMD_ERA32K:          m = MD_ERA32K;
      CMD_ERA64K:          m = MD_ERA64K;
      CMD_ALL_A, CMD_ALL_B: m = MD_ERAALL;
      CMD_SLEEP:           m = MD_SLEEP;
      CMD_JID:             m = MD_JID;
      CMD_LEGID:           m = MD_LEGID;
      CMD_MFID:            m = MD_MFID;
      default:             m = MD_NONE;
    endcase
    if (busy && m != MD_STAT1) m = MD_NONE;
    return m;
  endfunction

  function automatic logic is_read(input mode_t m);
    return (m == MD_STAT1) || (m == MD_STAT2) || (m == MD_JID) ||
           (m == MD_LEGID) || (m == MD_MFID);
  endfunction

endpackage

// File: rtl/sflash_pin_sync.sv
module sflash_pin_sync #(
  parameter int           STAGES  = 2,
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/sflash_resp_sel.sv
module sflash_resp_sel import sflash_fe_pkg::*; #(
  parameter int          BC_W       = 3,
  parameter int          ADDR_BYTES = 3,
  parameter logic [7:0]  MFR_ID     = 8'hEF,
  parameter logic [15:0] DEV_ID     = 16'h4015,
  parameter logic [7:0]  LEG_ID     = 8'h14
) (
  input  mode_t           mode,
  input  logic [BC_W-1:0] idx,
  input  logic [7:0]      stat1,
  input  logic [7:0]      stat2,
  output logic [7:0]      rbyte
);

  localparam logic [BC_W-1:0] AB = BC_W'(ADDR_BYTES);

  always_comb begin
    rbyte = '0;
    case (mode)
      MD_STAT1: rbyte = stat1;
      MD_STAT2: rbyte = stat2;
      MD_JID: begin
        if      (idx == BC_W'(0)) rbyte = MFR_ID;
        else if (idx == BC_W'(1)) rbyte = DEV_ID[15:8];
        else if (idx == BC_W'(2)) rbyte = DEV_ID[7:0];
      end
      MD_LEGID: if (idx >= AB) rbyte = LEG_ID;
      MD_MFID: begin
        if      (idx == AB) rbyte = MFR_ID;
        else if (idx > AB)  rbyte = LEG_ID;
      end
      default: rbyte = '0;
    endcase
  end

endmodule

// File: rtl/sflash_cmd_fe.sv
module sflash_cmd_fe import sflash_fe_pkg::*; #(
  parameter int          ADDR_W      = 24,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  MFR_ID      = 8'hEF,
  parameter logic [15:0] DEV_ID      = 16'h4015,
  parameter logic [7:0]  LEG_ID      = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              bk_busy,
  input  logic [5:0]        bk_stat_hi,
  input  logic [7:0]        bk_stat2,
  output logic              req_vld,
  output logic [2:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [15:0]       req_sr,
  output logic              req_sr_two,
  output logic              pgm_vld,
  output logic [7:0]        pgm_byte
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int BYTE_CAP   = ADDR_BYTES + 2;
  localparam int BC_W       = $clog2(BYTE_CAP + 1);
  localparam logic [BC_W-1:0] BC_CAP  = BC_W'(BYTE_CAP);
  localparam logic [BC_W-1:0] BC_ADDR = BC_W'(ADDR_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // pin synchronizers: bit0 select, bit1 clock, bit2 data
  logic [2:0] pins_s;
  sflash_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_sn), .din({si, sck, cs_n}), .dout(pins_s)
  );
  logic cs_s, sck_s, si_s;
  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[2];

  // state
  logic              cs_p, sck_p, busy_p;
  logic [2:0]        bitc,  bitc_n;
  logic [BC_W-1:0]   bytec, bytec_n;
  logic [6:0]        sh,    sh_n;
  mode_t             mode,  mode_n;
  logic [ADDR_W-1:0] addr,  addr_n;
  logic [15:0]       srd,   srd_n;
  logic              wel,   wel_n;
  logic              so_q,  so_n, oe_q, oe_n;
  logic              rv_q,  rv_n, two_q, two_n;
  req_kind_t         rk_q,  rk_n;
  logic              pv_q,  pv_n;
  logic [7:0]        pb_q,  pb_n;

  // edge strobes
  logic sck_r, sck_f, cs_f, cs_r, byte_done, aligned;
  logic [7:0] in_byte, stat1, rbyte;
  mode_t      dec_mode;
  assign sck_r     = sck_s & ~sck_p & ~cs_s;
  assign sck_f     = ~sck_s & sck_p & ~cs_s;
  assign cs_f      = ~cs_s & cs_p;
  assign cs_r      = cs_s & ~cs_p;
  assign byte_done = sck_r & (bitc == 3'd7);
  assign aligned   = (bitc == 3'd0);
  assign in_byte   = {sh, si_s};
  assign stat1     = {bk_stat_hi, wel, bk_busy};
  assign dec_mode  = cmd_decode(in_byte, bk_busy);

  sflash_resp_sel #(
    .BC_W(BC_W), .ADDR_BYTES(ADDR_BYTES),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .LEG_ID(LEG_ID)
  ) u_resp (
    .mode(mode), .idx(bytec - BC_W'(1)), .stat1(stat1), .stat2(bk_stat2), .rbyte(rbyte)
  );

  // next state
  always_comb begin
    bitc_n  = bitc;   bytec_n = bytec;  sh_n  = sh;    mode_n = mode;
    addr_n  = addr;   srd_n   = srd;    wel_n = wel;   so_n   = so_q;
    oe_n    = oe_q;   rv_n    = 1'b0;   rk_n  = rk_q;  two_n  = two_q;
    pv_n    = 1'b0;   pb_n    = pb_q;
    if (cs_f) begin
      bitc_n = '0; bytec_n = '0; mode_n = MD_NONE; oe_n = 1'b0; so_n = 1'b0;
    end else if (cs_r) begin
      oe_n = 1'b0; so_n = 1'b0; mode_n = MD_NONE;
      if (aligned) begin
        case (mode)
          MD_WEN:  wel_n = 1'b1;
          MD_WDIS: wel_n = 1'b0;
          MD_STWR: if (wel && bytec >= BC_W'(2)) begin
            rv_n = 1'b1; rk_n = RK_STWR; two_n = (bytec >= BC_W'(3));
          end
          MD_PROG:   if (wel && bytec >= BC_ADDR + BC_W'(2)) begin rv_n = 1'b1; rk_n = RK_PROG;   end
          MD_ERA4K:  if (wel && bytec >= BC_ADDR + BC_W'(1)) begin rv_n = 1'b1; rk_n = RK_ERA4K;  end
          MD_ERA32K: if (wel && bytec >= BC_ADDR + BC_W'(1)) begin rv_n = 1'b1; rk_n = RK_ERA32K; end
          MD_ERA64K: if (wel && bytec >= BC_ADDR + BC_W'(1)) begin rv_n = 1'b1; rk_n = RK_ERA64K; end
          MD_ERAALL: if (wel) begin rv_n = 1'b1; rk_n = RK_ERAALL; end
          MD_SLEEP:  begin rv_n = 1'b1; rk_n = RK_SLEEP; end
          default: ;
        endcase
      end
    end else begin
      if (sck_r) begin
        sh_n   = in_byte[6:0];
        bitc_n = bitc + 3'd1;
      end
      if (byte_done) begin
        bytec_n = (bytec == BC_CAP) ? bytec : bytec + BC_W'(1);
        if (bytec == '0) begin
          mode_n = dec_mode;
          oe_n   = is_read(dec_mode);
        end else begin
          if (bytec <= BC_ADDR && (mode == MD_PROG || mode == MD_ERA4K ||
              mode == MD_ERA32K || mode == MD_ERA64K))
            addr_n = {addr[ADDR_W-9:0], in_byte};
          if (mode == MD_PROG && bytec > BC_ADDR && wel) begin
            pv_n = 1'b1; pb_n = in_byte;
          end
          if (mode == MD_STWR && bytec == BC_W'(1)) srd_n[7:0]  = in_byte;
          if (mode == MD_STWR && bytec == BC_W'(2)) srd_n[15:8] = in_byte;
        end
      end
      if (sck_f && oe_q) so_n = rbyte[~bitc];
    end
    if (busy_p && !bk_busy) wel_n = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cs_p <= 1'b1;  sck_p <= 1'b0;  busy_p <= 1'b0;
      bitc <= '0;    bytec <= '0;    sh     <= '0;   mode <= MD_NONE;
      addr <= '0;    srd   <= '0;    wel    <= 1'b0;
      so_q <= 1'b0;  oe_q  <= 1'b0;  rv_q   <= 1'b0; rk_q <= RK_STWR;
      two_q <= 1'b0; pv_q  <= 1'b0;  pb_q   <= '0;
    end else begin
      cs_p <= cs_s;  sck_p <= sck_s; busy_p <= bk_busy;
      bitc <= bitc_n; bytec <= bytec_n; sh <= sh_n; mode <= mode_n;
      addr <= addr_n; srd <= srd_n; wel <= wel_n;
      so_q <= so_n;  oe_q <= oe_n;  rv_q <= rv_n;  rk_q <= rk_n;
      two_q <= two_n; pv_q <= pv_n; pb_q <= pb_n;
    end
  end

  assign so         = so_q;
  assign so_oe      = oe_q;
  assign req_vld    = rv_q;
  assign req_kind   = rk_q;
  assign req_addr   = addr;
  assign req_sr     = srd;
  assign req_sr_two = two_q;
  assign pgm_vld    = pv_q;
  assign pgm_byte   = pb_q;

  // R6
  req_on_release_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    req_vld |-> $past(cs_r));
  // R7
  req_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_vld && rk_q != RK_SLEEP) |-> $past(wel));
  // R8
  req_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    req_vld |-> !$past(bk_busy));
  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_p && !bk_busy) |=> !wel);
  // R10
  oe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(cs_s) && cs_s) |-> (!so_oe && !so));
  // R5
  pgm_wel_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    pgm_vld |-> ($past(wel) && !$past(cs_s)));

endmodule

// File: tb/sflash_cmd_fe_tb.sv
module sflash_cmd_fe_tb;

  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe, bk_busy;
  logic [5:0] bk_stat_hi = 6'b101100;
  logic [7:0] bk_stat2   = 8'h5A;
  logic req_vld, req_sr_two, pgm_vld;
  logic [2:0] req_kind;
  logic [23:0] req_addr;
  logic [15:0] req_sr;
  logic [7:0] pgm_byte;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sflash_cmd_fe u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .bk_busy(bk_busy), .bk_stat_hi(bk_stat_hi), .bk_stat2(bk_stat2),
    .req_vld(req_vld), .req_kind(req_kind), .req_addr(req_addr), .req_sr(req_sr),
    .req_sr_two(req_sr_two), .pgm_vld(pgm_vld), .pgm_byte(pgm_byte)
  );

  // backend stub
  int req_cnt = 0, pgm_cnt = 0, busy_left = 0;
  logic [2:0]  lk = '0;
  logic [23:0] la = '0;
  logic [15:0] ls = '0;
  logic        l2 = 1'b0;
  logic [7:0]  lp = '0;
  assign bk_busy = (busy_left != 0);
  always @(posedge clk) begin
    if (req_vld) begin
      req_cnt <= req_cnt + 1; lk <= req_kind; la <= req_addr; ls <= req_sr; l2 <= req_sr_two;
      if (req_kind != 3'd6) busy_left <= 600;
    end else if (busy_left != 0) busy_left <= busy_left - 1;
    if (pgm_vld) begin pgm_cnt <= pgm_cnt + 1; lp <= pgm_byte; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [63:0] miso;
  bit oe_seen;

  task automatic txn(input logic [63:0] mosi, input int nbits);
    miso = '0; oe_seen = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    clks(H);
    for (int i = 0; i < nbits; i++) begin
      si = mosi[nbits-1-i];
      clks(H);
      miso = {miso[62:0], so};
      oe_seen |= so_oe;
      sck = 1'b1;
      clks(H);
      oe_seen |= so_oe;
      sck = 1'b0;
    end
    clks(H);
    cs_n = 1'b1;
    clks(12);
  endtask

  task automatic wait_idle();
    while (bk_busy) @(negedge clk);
    clks(6);
  endtask

  task automatic rd_stat(input string tag, input logic [7:0] exp);
    txn(64'h05000000, 32);
    chk(tag, miso[23:0], {3{exp}});
  endtask

  task automatic t_reset();
    chk("R10 reset so_oe", so_oe, 0);
    chk("R10 reset so", so, 0);
    chk("R10 reset req", req_cnt, 0);
    rd_stat("R2 reset status", 8'hB0);
  endtask

  task automatic t_latch();
    txn(64'h06, 8);
    chk("R10 oe on write cmd", oe_seen, 0);
    rd_stat("R2 R3 status after 06h", 8'hB2);
    chk("R3 oe during read", oe_seen, 1);
    txn(64'h04, 8);
    rd_stat("R2 status after 04h", 8'hB0);
    txn(64'h35000000, 32);
    chk("R3 second status stream", miso[23:0], 24'h5A5A5A);
  endtask

  task automatic t_ids();
    txn(64'h9F00000000, 40);
    chk("R4 9Fh id bytes", miso[31:0], 32'hEF401500);
    txn(64'hAB0000000000, 48);
    chk("R4 ABh legacy id", miso[15:0], 16'h1414);
    txn(64'h900000000000, 48);
    chk("R4 90h id pair", miso[15:0], 16'hEF14);
  endtask

  task automatic t_unknown();
    int n0 = req_cnt;
    txn(64'hFF00, 16);
    chk("R1 unknown no oe", oe_seen, 0);
    chk("R1 unknown no req", req_cnt - n0, 0);
  endtask

  task automatic t_unaligned();
    int n0 = req_cnt;
    txn(64'h06, 8);
    txn({32'h0, 31'h20123456 >> 1}, 31);
    chk("R6 short erase no req", req_cnt - n0, 0);
    rd_stat("R6 latch kept", 8'hB2);
    txn(64'h04, 8);
    txn(64'h0C, 9);
    rd_stat("R6 9-bit 06h ignored", 8'hB0);
  endtask

  task automatic t_erase_busy();
    int n0 = req_cnt;
    txn(64'h06, 8);
    txn(64'h20123456, 32);
    chk("R5 erase req", req_cnt - n0, 1);
    chk("R5 erase kind", lk, 2);
    chk("R5 erase addr", la, 24'h123456);
    rd_stat("R8 status while busy", 8'hB3);
    txn(64'h9F000000, 32);
    chk("R8 id ignored while busy", {oe_seen, miso[23:0]}, 0);
    txn(64'hD8ABCDEF, 32);
    chk("R8 erase ignored while busy", req_cnt - n0, 1);
    wait_idle();
    rd_stat("R9 latch cleared at end", 8'hB0);
    txn(64'h06, 8);
    txn(64'h52000100, 32);
    chk("R5 32K erase kind", {lk, la}, {3'd3, 24'h000100});
    wait_idle();
    txn(64'h06, 8);
    txn(64'hD8FF0000, 32);
    chk("R5 64K erase kind", {lk, la}, {3'd4, 24'hFF0000});
    wait_idle();
  endtask

  task automatic t_no_wel();
    int n0 = req_cnt;
    txn(64'h20000000, 32);
    txn(64'hC7, 8);
    txn(64'h013C, 16);
    chk("R7 no latch no req", req_cnt - n0, 0);
  endtask

  task automatic t_program();
    int n0 = req_cnt, p0 = pgm_cnt;
    txn(64'h06, 8);
    txn(64'h02ABCDEF1122, 48);
    chk("R5 program req", req_cnt - n0, 1);
    chk("R5 program kind addr", {lk, la}, {3'd1, 24'hABCDEF});
    chk("R5 program bytes", pgm_cnt - p0, 2);
    chk("R5 program last byte", lp, 8'h22);
    wait_idle();
    txn(64'h06, 8);
    txn(64'h02000010, 32);
    chk("R5 program without data", req_cnt - n0, 1);
    txn(64'h04, 8);
  endtask

  task automatic t_stwr();
    int n0 = req_cnt;
    txn(64'h06, 8);
    txn(64'h013C, 16);
    chk("R12 one byte", {lk, ls[7:0], l2}, {3'd0, 8'h3C, 1'b0});
    wait_idle();
    txn(64'h06, 8);
    txn(64'h013C7E, 24);
    chk("R12 two bytes", {lk, ls, l2}, {3'd0, 16'h7E3C, 1'b1});
    wait_idle();
    txn(64'h06, 8);
    txn(64'h01, 8);
    chk("R12 no data no req", req_cnt - n0, 2);
    txn(64'h04, 8);
  endtask

  task automatic t_chip_sleep();
    int n0 = req_cnt;
    txn(64'h06, 8);
    txn(64'h60, 8);
    chk("R13 erase-all 60h", {req_cnt - n0, 29'(lk)}, {32'd1, 29'd5});
    wait_idle();
    txn(64'h06, 8);
    txn(64'hC7, 8);
    chk("R13 erase-all C7h", {req_cnt - n0, 29'(lk)}, {32'd2, 29'd5});
    wait_idle();
    txn(64'hB9, 8);
    chk("R13 power-down", {req_cnt - n0, 29'(lk)}, {32'd3, 29'd6});
  endtask

  task automatic t_partial_read();
    txn(64'h0A0, 13);
    txn(64'h06, 8);
    rd_stat("R11 after cut read", 8'hB2);
    txn(64'h04, 8);
  endtask

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(10);
    t_reset();
    t_latch();
    t_ids();
    t_unknown();
    t_unaligned();
    t_erase_busy();
    t_no_wel();
    t_program();
    t_stwr();
    t_chip_sleep();
    t_partial_read();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule